// File: doc/BRIEF.md
# Solenoid Strike Pulse Sequencer

This block produces the drive timing for one solenoid-actuated note. A note-on strobe starts a sequence. The attack output rises and stays high for an attack time. After the attack ends, a hold delay runs. When the delay is over, the block sends a one-cycle hold-start request to a separate PWM stage. The hold condition then lasts until a note-off strobe arrives. Each duration is made of a coarse part and a fine part. The coarse part counts whole periods of 256 ticks. The fine part is a remainder period of fine+1 ticks.

Ticks come from an internal prescaler, whose ratio is chosen by a select input. The prescaler restarts on a note-on and whenever the select changes, so sequence timing is exact in clock cycles. The attack coarse value is limited to a ceiling input. A request above the ceiling is clamped, and a sticky error bit records it. All four timing values are captured at note-on. A state flag byte shows whether the attack phase or the hold phase is active.

Top module: `strike_seq`

## Requirements
- R1: After reset, attack_o, hold_start_o, state_flags_o and err_flags_o are all zero.
- R2: A note-on without a note-off in the same cycle sets attack_o in the next cycle and clears the hold flag. A note-on that arrives while a sequence is active restarts that sequence from the beginning.
- R3: attack_o stays high for exactly ((C+1)*256 + F + 1) ticks after a note-on. Here C is the effective attack coarse value and F is the attack fine value.
- R4: After attack_o falls, a further (D*256 + E + 1) ticks pass, where D is the delay coarse value and E is the delay fine value. Then hold_start_o pulses high for one cycle, and state_flags_o bit 1 is set in that same cycle. hold_start_o is never high while attack_o is high.
- R5: The effective coarse value C is min(atk_coarse, max_coarse). If atk_coarse > max_coarse at a note-on, err_flags_o bit 2 (value 0x04) is set and stays set until reset. All other error bits stay zero.
- R6: The psc_sel codes give one tick every 1, 8, 64, 256 or 1024 cycles for codes 1, 2, 3, 4 and 5. Codes 0, 6 and 7 produce no ticks, so the sequence freezes in its current phase.
- R7: The prescaler count restarts on a note-on and on any change of psc_sel. After either event, the first tick arrives one full divide period later.
- R8: A note-off clears attack_o and both flag bits in the next cycle, and it aborts the sequence so that no hold_start_o follows. A note-off takes priority over a note-on in the same cycle.
- R9: state_flags_o bit 0 equals attack_o, bit 1 is the hold flag, and bits 7:2 are zero.
- R10: Timing inputs that change after a note-on do not alter the sequence that note-on started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psc_sel | input | 3 | Tick prescaler select code |
| note_on | input | 1 | Start/restart strobe |
| note_off | input | 1 | Abort/release strobe |
| atk_coarse | input | 8 | Requested attack coarse periods |
| atk_fine | input | 8 | Attack fine compare value |
| max_coarse | input | 8 | Ceiling for attack coarse |
| dly_coarse | input | 8 | Hold delay coarse periods |
| dly_fine | input | 8 | Hold delay fine compare value |
| attack_o | output | 1 | Attack drive output |
| hold_start_o | output | 1 | One-cycle hold-enable request to the PWM stage |
| state_flags_o | output | 8 | Bit 0 attack, bit 1 hold |
| err_flags_o | output | 8 | Bit 2 is the sticky coarse-clamp error |

## Verification
A sweep covers attack coarse 0 and 1, attack fine 0 and 255, delay coarse 0 and 1, and delay fine 0 and 7. Because of this, an off-by-one in the coarse+1 rule, in the fine+1 remainder, or in the zero-delay-coarse bypass shows up as a distinct cycle count. Further runs use the ÷8 and ÷64 ratios, switch the ratio in the middle of a run, use a frozen select code, and raise the coarse request above the ceiling. These separate a prescaler that multiplies correctly from one that keeps a stale phase, and a clamp from a pass-through. Other runs restart the sequence mid-run, apply note-off mid-attack, assert note-on and note-off together, and change the timing inputs during a run. These show that restart, abort priority and input capture are each handled.

// File: rtl/strike_pkg.sv
package strike_pkg;

    localparam int REG_W = 8;
    localparam int SEL_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ATK_C = 3'd1,
        PH_ATK_F = 3'd2,
        PH_DLY_C = 3'd3,
        PH_DLY_E = 3'd4
    } phase_e;

    typedef struct packed {
        logic [REG_W-1:0] coarse;
        logic [REG_W-1:0] fine;
        logic [REG_W-1:0] dcoarse;
        logic [REG_W-1:0] dfine;
    } timing_t;

    function automatic logic psc_valid(input logic [SEL_W-1:0] sel);
        return (sel >= 3'd1) && (sel <= 3'd5);
    endfunction

    function automatic int psc_shift(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/strike_tick_gen.sv
module strike_tick_gen
    import strike_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tick
);
    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] lim;
    logic             changed;
    logic             valid;

    always_comb begin
        valid   = psc_valid(sel);
        lim     = DIV_W'((32'd1 << psc_shift(sel)) - 32'd1);
        changed = (sel != sel_q);
        tick    = valid && !changed && !restart && (pcnt == lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            pcnt  <= '0;
        end else begin
            sel_q <= sel;
            if (changed || restart || !valid || (pcnt == lim))
                pcnt <= '0;
            else
                pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/strike_phase_core.sv
module strike_phase_core
    import strike_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    start,
    input  logic    stop,
    input  timing_t cfg,
    output logic    attack,
    output logic    hold_flag,
    output logic    hold_go
);
    phase_e           phase;
    timing_t          cfg_q;
    logic [REG_W-1:0] tcnt;
    logic [REG_W-1:0] ccnt;
    logic [REG_W-1:0] cmp;
    logic             period_done;

    assign period_done = tick && (phase != PH_IDLE) && (tcnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg_q     <= '0;
            tcnt      <= '0;
            ccnt      <= '0;
            cmp       <= '0;
            attack    <= 1'b0;
            hold_flag <= 1'b0;
            hold_go   <= 1'b0;
        end else begin
            hold_go <= 1'b0;
            if (stop) begin
                phase     <= PH_IDLE;
                attack    <= 1'b0;
                hold_flag <= 1'b0;
            end else if (start) begin
                cfg_q     <= cfg;
                phase     <= PH_ATK_C;
                tcnt      <= '0;
                ccnt      <= '0;
                cmp       <= '1;
                attack    <= 1'b1;
                hold_flag <= 1'b0;
            end else if (tick && phase != PH_IDLE) begin
                if (!period_done) begin
                    tcnt <= tcnt + 1'b1;
                end else begin
                    tcnt <= '0;
                    case (phase)
                        PH_ATK_C: begin
                            if (ccnt == cfg_q.coarse) begin
                                phase <= PH_ATK_F;
                                cmp   <= cfg_q.fine;
                            end else begin
                                ccnt <= ccnt + 1'b1;
                            end
                        end
                        PH_ATK_F: begin
                            attack <= 1'b0;
                            if (cfg_q.dcoarse != '0) begin
                                phase <= PH_DLY_C;
                                ccnt  <= '0;
                                cmp   <= '1;
                            end else begin
                                phase <= PH_DLY_E;
                                cmp   <= cfg_q.dfine;
                            end
                        end
                        PH_DLY_C: begin
                            if (REG_W'(ccnt + 1'b1) == cfg_q.dcoarse) begin
                                phase <= PH_DLY_E;
                                cmp   <= cfg_q.dfine;
                            end else begin
                                ccnt <= ccnt + 1'b1;
                            end
                        end
                        PH_DLY_E: begin
                            phase     <= PH_IDLE;
                            hold_flag <= 1'b1;
                            hold_go   <= 1'b1;
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/strike_seq.sv
module strike_seq
    import strike_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] psc_sel,
    input  logic             note_on,
    input  logic             note_off,
    input  logic [REG_W-1:0] atk_coarse,
    input  logic [REG_W-1:0] atk_fine,
    input  logic [REG_W-1:0] max_coarse,
    input  logic [REG_W-1:0] dly_coarse,
    input  logic [REG_W-1:0] dly_fine,
    output logic             attack_o,
    output logic             hold_start_o,
    output logic [REG_W-1:0] state_flags_o,
    output logic [REG_W-1:0] err_flags_o
);
    localparam int CLAMP_BIT = 2;

    logic    start;
    logic    over;
    logic    tick;
    logic    hold_flag;
    logic    clamp_err;
    timing_t cfg;

    assign start = note_on && !note_off;
    assign over  = (atk_coarse > max_coarse);

    always_comb begin
        cfg.coarse  = over ? max_coarse : atk_coarse;
        cfg.fine    = atk_fine;
        cfg.dcoarse = dly_coarse;
        cfg.dfine   = dly_fine;
    end

    strike_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .sel     (psc_sel),
        .restart (start),
        .tick    (tick)
    );

    strike_phase_core core_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (start),
        .stop      (note_off),
        .cfg       (cfg),
        .attack    (attack_o),
        .hold_flag (hold_flag),
        .hold_go   (hold_start_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            clamp_err <= 1'b0;
        else if (start && over)
            clamp_err <= 1'b1;
    end

    always_comb begin
        state_flags_o    = '0;
        state_flags_o[0] = attack_o;
        state_flags_o[1] = hold_flag;
        err_flags_o            = '0;
        err_flags_o[CLAMP_BIT] = clamp_err;
    end
endmodule

// File: rtl/strike_seq_chk.sv
module strike_seq_chk
    import strike_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             note_on,
    input logic             note_off,
    input logic [REG_W-1:0] atk_coarse,
    input logic [REG_W-1:0] max_coarse,
    input logic             attack_o,
    input logic             hold_start_o,
    input logic [REG_W-1:0] state_flags_o,
    input logic [REG_W-1:0] err_flags_o
);
    AST_START_RAISES_ATTACK: assert property (@(posedge clk) disable iff (rst)
        (note_on && !note_off) |=> (attack_o && !state_flags_o[1])); // R2

    AST_ATTACK_ONLY_BY_START: assert property (@(posedge clk) disable iff (rst)
        $rose(attack_o) |-> $past(note_on && !note_off)); // R2

    AST_STOP_CLEARS_ALL: assert property (@(posedge clk) disable iff (rst)
        note_off |=> (!attack_o && state_flags_o[1:0] == 2'b00 && !hold_start_o)); // R8

    AST_HOLD_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hold_start_o |=> !hold_start_o); // R4

    AST_HOLD_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(state_flags_o[1]) |-> hold_start_o); // R4

    AST_HOLD_NOT_IN_ATTACK: assert property (@(posedge clk) disable iff (rst)
        hold_start_o |-> !attack_o); // R4

    AST_CLAMP_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        (note_on && !note_off && atk_coarse > max_coarse) |=> err_flags_o[2]); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_flags_o[2] |=> err_flags_o[2]); // R5
endmodule

bind strike_seq strike_seq_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .note_on       (note_on),
    .note_off      (note_off),
    .atk_coarse    (atk_coarse),
    .max_coarse    (max_coarse),
    .attack_o      (attack_o),
    .hold_start_o  (hold_start_o),
    .state_flags_o (state_flags_o),
    .err_flags_o   (err_flags_o)
);

// File: tb/strike_seq_tb.sv
module strike_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] psc_sel = 3'd1;
    logic       note_on = 1'b0;
    logic       note_off = 1'b0;
    logic [7:0] atk_coarse = 8'd0;
    logic [7:0] atk_fine = 8'd0;
    logic [7:0] max_coarse = 8'd14;
    logic [7:0] dly_coarse = 8'd0;
    logic [7:0] dly_fine = 8'd0;
    logic       attack_o;
    logic       hold_start_o;
    logic [7:0] state_flags_o;
    logic [7:0] err_flags_o;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    strike_seq dut_i (
        .clk(clk), .rst(rst), .psc_sel(psc_sel), .note_on(note_on), .note_off(note_off),
        .atk_coarse(atk_coarse), .atk_fine(atk_fine), .max_coarse(max_coarse),
        .dly_coarse(dly_coarse), .dly_fine(dly_fine), .attack_o(attack_o),
        .hold_start_o(hold_start_o), .state_flags_o(state_flags_o), .err_flags_o(err_flags_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    // chg_kind: 0 none, 1 switch prescaler to chg_sel, 2 alter timing inputs
    task automatic run_seq(input int exp_atk, input int exp_hold, input int chg_kind,
                           input int chg_at, input logic [2:0] chg_sel, input string req);
        int idx = 1;
        int atk_cnt = 0;
        int hold_idx = 0;
        int flags_at_hold = 0;
        int flags_first = 0;
        @(negedge clk);
        note_on = 1'b1;
        @(negedge clk);
        note_on = 1'b0;
        flags_first = int'(state_flags_o);
        while (hold_idx == 0 && idx < exp_hold + 20) begin
            if (attack_o) atk_cnt++;
            if (hold_start_o) begin
                hold_idx = idx;
                flags_at_hold = int'(state_flags_o);
            end
            if (idx == chg_at && chg_kind == 1) psc_sel = chg_sel;
            if (idx == chg_at && chg_kind == 2) begin
                atk_coarse = 8'd9;
                atk_fine = 8'd77;
                dly_coarse = 8'd3;
                dly_fine = 8'd50;
            end
            @(negedge clk);
            idx++;
        end
        chk(flags_first == 1, {req, " R9 flags in attack"}, flags_first, 1);
        chk(atk_cnt == exp_atk, {req, " R3 attack length"}, atk_cnt, exp_atk);
        chk(hold_idx == exp_hold, {req, " R4 hold start position"}, hold_idx, exp_hold);
        chk(flags_at_hold == 2, {req, " R4 R9 flags at hold"}, flags_at_hold, 2);
    endtask

    initial begin
        int ta;
        int th;
        int wait_hits;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(attack_o == 1'b0 && hold_start_o == 1'b0, "R1 outputs", int'(attack_o), 0);
        chk(state_flags_o == 8'd0, "R1 flags", int'(state_flags_o), 0);
        chk(err_flags_o == 8'd0, "R1 err", int'(err_flags_o), 0);

        // Default-like timing, divide by 1
        atk_coarse = 8'd5; atk_fine = 8'd0; dly_coarse = 8'd0; dly_fine = 8'd6;
        ta = 6 * 256 + 1;
        th = ta + 7;
        run_seq(ta, th + 1, 0, 0, 3'd1, "R3 default");
        chk(err_flags_o == 8'd0, "R5 no clamp no error", int'(err_flags_o), 0);

        // Sweep over small configurations
        for (int c = 0; c < 2; c++)
            for (int f = 0; f < 2; f++)
                for (int d = 0; d < 2; d++)
                    for (int e = 0; e < 2; e++) begin
                        atk_coarse = 8'(c);
                        atk_fine = (f != 0) ? 8'd255 : 8'd0;
                        dly_coarse = 8'(d);
                        dly_fine = (e != 0) ? 8'd7 : 8'd0;
                        ta = (c + 1) * 256 + int'(atk_fine) + 1;
                        th = ta + d * 256 + int'(dly_fine) + 1;
                        run_seq(ta, th + 1, 0, 0, 3'd1, "R3 R4 sweep");
                    end

        // Larger delay coarse path
        atk_coarse = 8'd0; atk_fine = 8'd10; dly_coarse = 8'd2; dly_fine = 8'd3;
        ta = 256 + 11;
        th = ta + 512 + 4;
        run_seq(ta, th + 1, 0, 0, 3'd1, "R4 delay coarse 2");

        // R5 clamp
        atk_coarse = 8'd20; max_coarse = 8'd3; atk_fine = 8'd0; dly_coarse = 8'd0; dly_fine = 8'd0;
        ta = 4 * 256 + 1;
        run_seq(ta, ta + 2, 0, 0, 3'd1, "R5 clamp");
        chk(err_flags_o == 8'h04, "R5 clamp error bit", int'(err_flags_o), 4);
        atk_coarse = 8'd0; max_coarse = 8'd14;
        run_seq(257, 259, 0, 0, 3'd1, "R5 sticky run");
        chk(err_flags_o == 8'h04, "R5 error sticky", int'(err_flags_o), 4);

        // R6 prescaler ratios
        psc_sel = 3'd2;
        run_seq(257 * 8, 258 * 8 + 1, 0, 0, 3'd1, "R6 div8");
        psc_sel = 3'd3;
        run_seq(257 * 64, 258 * 64 + 1, 0, 0, 3'd1, "R6 div64");

        // R7 prescaler switch mid-run from div8 to div1
        psc_sel = 3'd2;
        run_seq(3 + 257, 4 + 258, 1, 3, 3'd1, "R7 switch");

        // R10 inputs changed during run do not matter
        psc_sel = 3'd1;
        run_seq(257, 259, 2, 5, 3'd1, "R10 latch");
        atk_coarse = 8'd0; atk_fine = 8'd0; dly_coarse = 8'd0; dly_fine = 8'd0;

        // R2 restart during active attack
        @(negedge clk); note_on = 1'b1;
        @(negedge clk); note_on = 1'b0;
        repeat (100) @(negedge clk);
        run_seq(257, 259, 0, 0, 3'd1, "R2 restart");

        // R8 note-off mid-attack aborts
        @(negedge clk); note_on = 1'b1;
        @(negedge clk); note_on = 1'b0;
        repeat (50) @(negedge clk);
        note_off = 1'b1;
        @(negedge clk); note_off = 1'b0;
        chk(attack_o == 1'b0, "R8 attack cleared", int'(attack_o), 0);
        chk(state_flags_o == 8'd0, "R8 flags cleared", int'(state_flags_o), 0);
        wait_hits = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (hold_start_o || attack_o) wait_hits++;
        end
        chk(wait_hits == 0, "R8 no hold after abort", wait_hits, 0);

        // R8 note-off wins over simultaneous note-on
        note_on = 1'b1; note_off = 1'b1;
        @(negedge clk);
        note_on = 1'b0; note_off = 1'b0;
        chk(attack_o == 1'b0, "R8 off priority", int'(attack_o), 0);

        // R6 invalid select freezes sequence
        psc_sel = 3'd0;
        @(negedge clk); note_on = 1'b1;
        @(negedge clk); note_on = 1'b0;
        wait_hits = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!attack_o || hold_start_o) wait_hits++;
        end
        chk(wait_hits == 0, "R6 frozen on code 0", wait_hits, 0);
        chk(state_flags_o == 8'd1, "R9 flags while frozen", int'(state_flags_o), 1);
        note_off = 1'b1;
        @(negedge clk); note_off = 1'b0;
        psc_sel = 3'd1;
        @(negedge clk);
        chk(state_flags_o == 8'd0, "R8 flags after off", int'(state_flags_o), 0);

        finish_run();
    end
endmodule